// File: doc/BRIEF.md
# CPU Clock Source Selector and Ratio Divider

This block derives the CPU clock-enable stream on a single fast clock. Two source tick inputs stand for the crystal reference and the PLL output. A first selection level picks which source feeds a programmable divider. The divider can divide by 1, 2 or 3, or by an even ratio 2×N taken from a 9-bit field. An output selection level then sends either the raw crystal tick or the divided tick to the CPU enable output. Each output pulse marks one CPU clock period.

Two control words sit behind a simple write port and a combinational read port. The word at offset 0x40 holds the output select, the divider select and the source select. The word at offset 0x00 holds N.

A handover sequencer lets the system retune the PLL safely. On a pre-change request it parks the output on the crystal. It then waits 100 µs and points the divider input at the PLL. On a post-change request it returns the output to the divided path and waits another 100 µs. The wait length is derived from a reference-frequency parameter. Software computes a ratio as the input rate over the target rate, rounded up. A ratio of at most 3 is programmed as select = ratio−1. A larger ratio uses select = 3 with N = ratio/2, rounded down.

Top module: `cdm_cpu_clk`

## Requirements
- R1: After an active-low reset, both control words read as zero. The CPU enable output then equals the crystal tick input.
- R2: When bit 7 of the word at 0x40 is 0, the CPU enable output equals the crystal tick, whatever the divider and the PLL tick are doing.
- R3: Bit 0 of the word at 0x40 selects the divider's source: 0 takes crystal ticks and 1 takes PLL ticks. Ticks from the source that is not selected never advance the divider.
- R4: The divider select is bits [3:2] of the word at 0x40. Values 0, 1 and 2 make the divider emit one pulse on every 1st, 2nd or 3rd source tick.
- R5: Divider select 3 gives one pulse every 2×N source ticks, where N is bits [28:20] of the word at 0x00. When N is 0, the divider passes every source tick through.
- R6: A new divider select or N value is adopted only at the tick that ends the current period. The period in progress always completes with its old length.
- R7: A read of 0x40 returns its three fields at bits 7, [3:2] and 0, with zeros elsewhere. A read of 0x00 returns N at [28:20], with zeros elsewhere. A write to any other address changes neither word.
- R8: An accepted pre-change request clears bit 7 at the clock edge where it is sampled. Busy then stays high for exactly WAIT cycles, where WAIT = REF_HZ/10000. Bit 0 is set at the edge where busy drops.
- R9: An accepted post-change request sets bit 7 at the edge where it is sampled. Busy then stays high for exactly WAIT cycles.
- R10: A pre-change or post-change request that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock on which all ticks are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick_i | input | 1 | Crystal reference tick |
| pll_tick_i | input | 1 | PLL output tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| pre_req_i | input | 1 | Pulse requesting the pre-retune handover |
| post_req_i | input | 1 | Pulse requesting the post-retune handover |
| busy_o | output | 1 | High while a handover wait is running |
| cpu_en_o | output | 1 | CPU clock-enable pulse |

## Verification
Some properties are checked on every cycle. The divider count stays below the active divisor, and the divisor is never zero. The active divisor changes only on a period-ending tick. The wait counter stays inside its window. Each sequencer command reaches the control word on the next cycle, and no command is issued while busy. Writes to unmapped addresses leave both words untouched.

Other behaviour can only be shown by the bench's scenarios. These are the actual pulse spacing for every divider select and a sweep of N values, the blocking of the unselected source, and the completion of an old period after a mid-period reprogram. They also include the exact busy length and field contents across a full pre/post handover with stray requests injected.

// File: rtl/cdm_pkg.sv
package cdm_pkg;

    localparam int unsigned DATA_W      = 32;
    localparam int unsigned NDIV_W      = 9;
    localparam int unsigned DIV_W       = NDIV_W + 1;
    localparam int unsigned OUT_SEL_BIT = 7;
    localparam int unsigned DSEL_LSB    = 2;
    localparam int unsigned SRC_SEL_BIT = 0;
    localparam int unsigned NDIV_LSB    = 20;

    typedef struct packed {
        logic       out_sel;
        logic [1:0] dsel;
        logic       src_sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        HO_IDLE = 2'd0,
        HO_PRE  = 2'd1,
        HO_POST = 2'd2
    } ho_state_e;

    function automatic logic [DIV_W-1:0] divisor_of(input logic [1:0] dsel,
                                                    input logic [NDIV_W-1:0] n);
        logic [DIV_W-1:0] r;
        case (dsel)
            2'd0:    r = DIV_W'(1);
            2'd1:    r = DIV_W'(2);
            2'd2:    r = DIV_W'(3);
            default: r = (n == '0) ? DIV_W'(1) : {n, 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cdm_regs.sv
module cdm_regs
    import cdm_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 7,
    parameter logic [ADDR_W-1:0]  NDIV_ADDR = 7'h00,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 7'h40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 seq_out_clr,
    input  logic                 seq_out_set,
    input  logic                 seq_src_set,
    output ctrl_t                ctrl_o,
    output logic [NDIV_W-1:0]    ndiv_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [NDIV_W-1:0] ndiv;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_data_unused;

    assign wr_data_unused = ^{wr_data[31:29], wr_data[19:8], wr_data[6:4], wr_data[1]};

    always_comb begin
        r_d = r_q;
        if (wr_en && (wr_addr == CTRL_ADDR)) begin
            r_d.ctrl.out_sel = wr_data[OUT_SEL_BIT];
            r_d.ctrl.dsel    = wr_data[DSEL_LSB +: 2];
            r_d.ctrl.src_sel = wr_data[SRC_SEL_BIT];
        end
        if (wr_en && (wr_addr == NDIV_ADDR)) begin
            r_d.ndiv = wr_data[NDIV_LSB +: NDIV_W];
        end
        if (seq_out_clr) r_d.ctrl.out_sel = 1'b0;
        if (seq_out_set) r_d.ctrl.out_sel = 1'b1;
        if (seq_src_set) r_d.ctrl.src_sel = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR) begin
            rd_data[OUT_SEL_BIT]   = r_q.ctrl.out_sel;
            rd_data[DSEL_LSB +: 2] = r_q.ctrl.dsel;
            rd_data[SRC_SEL_BIT]   = r_q.ctrl.src_sel;
        end else if (rd_addr == NDIV_ADDR) begin
            rd_data[NDIV_LSB +: NDIV_W] = r_q.ndiv;
        end
    end

    assign ctrl_o = r_q.ctrl;
    assign ndiv_o = r_q.ndiv;

    // R8: the park command lands in the control word on the next cycle
    assert_park_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_out_clr |=> !ctrl_o.out_sel);
    // R8: the source switch lands on the next cycle
    assert_src_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_src_set |=> ctrl_o.src_sel);
    // R9: the restore command lands on the next cycle
    assert_restore_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_out_set |=> ctrl_o.out_sel);
    // R7: writes to unmapped addresses leave both words untouched
    assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_ADDR && wr_addr != NDIV_ADDR &&
         !seq_out_clr && !seq_out_set && !seq_src_set) |=> $stable(r_q));

endmodule

// File: rtl/cdm_handover.sv
module cdm_handover
    import cdm_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_req,
    input  logic post_req,
    output logic busy_o,
    output logic out_clr_o,
    output logic out_set_o,
    output logic src_set_o
);

    localparam int unsigned CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    typedef struct packed {
        ho_state_e        state;
        logic [CNT_W-1:0] cnt;
    } ho_t;

    ho_t  h_d, h_q;
    logic done;

    assign done = (h_q.cnt == LAST);

    always_comb begin
        h_d       = h_q;
        out_clr_o = 1'b0;
        out_set_o = 1'b0;
        src_set_o = 1'b0;
        case (h_q.state)
            HO_IDLE: begin
                h_d.cnt = '0;
                if (pre_req) begin
                    out_clr_o = 1'b1;
                    h_d.state = HO_PRE;
                end else if (post_req) begin
                    out_set_o = 1'b1;
                    h_d.state = HO_POST;
                end
            end
            HO_PRE: begin
                if (done) begin
                    src_set_o = 1'b1;
                    h_d.state = HO_IDLE;
                    h_d.cnt   = '0;
                end else begin
                    h_d.cnt = h_q.cnt + 1'b1;
                end
            end
            HO_POST: begin
                if (done) begin
                    h_d.state = HO_IDLE;
                    h_d.cnt   = '0;
                end else begin
                    h_d.cnt = h_q.cnt + 1'b1;
                end
            end
            default: begin
                h_d.state = HO_IDLE;
                h_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{state: HO_IDLE, cnt: '0};
        else        h_q <= h_d;
    end

    assign busy_o = (h_q.state != HO_IDLE);

    // R8: wait counter never leaves its window
    assert_wait_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.cnt <= LAST);
    // R8: an idle pre request starts the parked wait
    assert_pre_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && pre_req) |=> (h_q.state == HO_PRE));
    // R10: no park or restore command is issued while busy
    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(out_clr_o || out_set_o));

endmodule

// File: rtl/cdm_divider.sv
module cdm_divider
    import cdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_tick,
    input  logic [1:0]        dsel,
    input  logic [NDIV_W-1:0] ndiv,
    output logic              div_en_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } dv_t;

    dv_t  v_d, v_q;
    logic last;
    logic wrap;

    assign last = (v_q.cnt == (v_q.div - 1'b1));
    assign wrap = src_tick && last;

    always_comb begin
        v_d = v_q;
        if (src_tick) begin
            if (last) begin
                v_d.cnt = '0;
                v_d.div = divisor_of(dsel, ndiv);
            end else begin
                v_d.cnt = v_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '{div: DIV_W'(1), cnt: '0};
        else        v_q <= v_d;
    end

    assign div_en_o = wrap;

    // R4: the count stays inside the active period
    assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_q.cnt < v_q.div);
    // R5: the active divisor is never zero
    assert_div_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        v_q.div != '0);
    // R6: the divisor only moves on a period-ending tick
    assert_div_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(v_q.div));

endmodule

// File: rtl/cdm_cpu_clk.sv
module cdm_cpu_clk
    import cdm_pkg::*;
#(
    parameter int unsigned       REF_HZ    = 50_000_000,
    parameter int unsigned       ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] NDIV_ADDR = 7'h00,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_tick_i,
    input  logic              pll_tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    input  logic              pre_req_i,
    input  logic              post_req_i,
    output logic              busy_o,
    output logic              cpu_en_o
);

    localparam int unsigned WAIT_RAW = REF_HZ / 10000;
    localparam int unsigned WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

    ctrl_t             ctrl;
    logic [NDIV_W-1:0] ndiv;
    logic              out_clr, out_set, src_set;
    logic              src_tick;
    logic              div_en;

    cdm_handover #(.WAIT_CYC(WAIT_CYC)) u_ho (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_req   (pre_req_i),
        .post_req  (post_req_i),
        .busy_o    (busy_o),
        .out_clr_o (out_clr),
        .out_set_o (out_set),
        .src_set_o (src_set)
    );

    cdm_regs #(
        .ADDR_W    (ADDR_W),
        .NDIV_ADDR (NDIV_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en_i),
        .wr_addr     (wr_addr_i),
        .wr_data     (wr_data_i),
        .rd_addr     (rd_addr_i),
        .rd_data     (rd_data_o),
        .seq_out_clr (out_clr),
        .seq_out_set (out_set),
        .seq_src_set (src_set),
        .ctrl_o      (ctrl),
        .ndiv_o      (ndiv)
    );

    assign src_tick = ctrl.src_sel ? pll_tick_i : xtal_tick_i;

    cdm_divider u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .dsel     (ctrl.dsel),
        .ndiv     (ndiv),
        .div_en_o (div_en)
    );

    assign cpu_en_o = ctrl.out_sel ? div_en : xtal_tick_i;

    // R8: sequencer commands never collide
    assert_cmd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_clr, out_set, src_set}));
    // R2: with the output parked, the enable follows the crystal tick
    assert_parked_follows_xtal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.out_sel |-> (cpu_en_o == xtal_tick_i));

endmodule

// File: tb/sim_cdm_cpu_clk.sv
module sim_cdm_cpu_clk;

    localparam int unsigned REF_HZ = 100_000;
    localparam int          WAIT   = 10;
    localparam logic [6:0]  A_N    = 7'h00;
    localparam logic [6:0]  A_C    = 7'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xt = 1'b0, pt = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic        pre = 1'b0, post = 1'b0;
    logic        busy, cpu_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cdm_cpu_clk #(.REF_HZ(REF_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .xtal_tick_i(xt), .pll_tick_i(pt),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pre_req_i(pre), .post_req_i(post), .busy_o(busy), .cpu_en_o(cpu_en)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    // one cycle with the given ticks; returns the enable seen in that cycle
    task automatic tick(input bit x, input bit p, output bit got);
        @(negedge clk);
        xt = x; pt = p;
        #2 got = cpu_en;
        @(posedge clk); #1;
        xt = 1'b0; pt = 1'b0;
    endtask

    // advance PLL ticks until the current period ends
    task automatic align();
        bit g;
        g = 1'b0;
        for (int i = 0; i < 3000 && !g; i++) tick(1'b0, 1'b1, g);
    endtask

    // count ticks up to and including the next pulse
    task automatic gap(output int n);
        bit g;
        g = 1'b0; n = 0;
        while (!g && n < 3000) begin tick(1'b0, 1'b1, g); n++; end
    endtask

    task automatic sweep(input logic [1:0] sel, input int n, input int exp, input string req);
        int k;
        wr(A_N, 32'(n) << 20);
        wr(A_C, 32'h81 | (32'(sel) << 2));
        align();
        for (int r = 0; r < 3; r++) begin
            gap(k);
            check(k == exp, req, k, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit g;
        int k;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(A_C, d); check(d == 0, "R1 ctrl", d, 0);
        rd(A_N, d); check(d == 0, "R1 ndiv", d, 0);
        tick(1'b1, 1'b0, g); check(g == 1'b1, "R1 xtal pass", g, 1);
        tick(1'b0, 1'b1, g); check(g == 1'b0, "R1 pll blocked", g, 0);

        // R7: field readback and unmapped writes
        wr(A_C, 32'hFFFF_FFFF); rd(A_C, d); check(d == 32'h8D, "R7 ctrl fields", d, 32'h8D);
        wr(A_N, 32'hFFFF_FFFF); rd(A_N, d); check(d == 32'h1FF0_0000, "R7 ndiv field", d, 32'h1FF0_0000);
        wr(7'h20, 32'h0); rd(A_C, d); check(d == 32'h8D, "R7 unmapped ctrl", d, 32'h8D);
        rd(A_N, d); check(d == 32'h1FF0_0000, "R7 unmapped ndiv", d, 32'h1FF0_0000);

        // R4: small ratios
        sweep(2'd0, 0, 1, "R4 div1");
        sweep(2'd1, 0, 2, "R4 div2");
        sweep(2'd2, 0, 3, "R4 div3");
        // R5: even ratios over a sweep of N, N=0 passes through
        sweep(2'd3, 0, 1, "R5 n0");
        for (int i = 1; i <= 12; i++) sweep(2'd3, i, 2 * i, "R5 n");
        sweep(2'd3, 100, 200, "R5 n100");
        sweep(2'd3, 511, 1022, "R5 n511");
        // R5: ratios from target rates (input 1000): ceil(1000/t)
        for (int t = 70; t <= 400; t += 110) begin
            int dv;
            dv = (1000 + t - 1) / t;
            sweep(2'd3, dv / 2, 2 * (dv / 2), "R5 rate");
        end

        // R3: unselected source does not advance the divider
        wr(A_C, 32'h85); align();
        g = 1'b0;
        for (int i = 0; i < 6; i++) begin bit h; tick(1'b1, 1'b0, h); g |= h; end
        check(g == 1'b0, "R3 xtal ignored", g, 0);
        gap(k); check(k == 2, "R3 pll counts", k, 2);
        wr(A_C, 32'h84); align();
        g = 1'b0;
        for (int i = 0; i < 6; i++) begin bit h; tick(1'b0, 1'b1, h); g |= h; end
        check(g == 1'b0, "R3 pll ignored", g, 0);
        k = 0; g = 1'b0;
        while (!g && k < 20) begin tick(1'b1, 1'b0, g); k++; end
        check(k == 2, "R3 xtal counts", k, 2);

        // R2: parked output follows crystal only
        wr(A_C, 32'h05);
        tick(1'b0, 1'b1, g); check(g == 1'b0, "R2 pll hidden", g, 0);
        tick(1'b1, 1'b0, g); check(g == 1'b1, "R2 xtal shown", g, 1);
        tick(1'b1, 1'b1, g); check(g == 1'b1, "R2 both", g, 1);

        // R6: mid-period reprogram completes old period
        wr(A_N, 32'(2) << 20); wr(A_C, 32'h8D); align(); align();
        tick(1'b0, 1'b1, g);
        wr(A_C, 32'h81);
        gap(k); check(k == 3, "R6 old period kept", k, 3);
        gap(k); check(k == 1, "R6 new period", k, 1);

        // R8 and R10: pre-change handover with a stray post request
        wr(A_C, 32'h8C);
        @(negedge clk); pre = 1'b1;
        @(posedge clk); #1 pre = 1'b0;
        rd(A_C, d); check(d == 32'h0C, "R8 parked", d, 32'h0C);
        n = 0;
        while (busy && n < 100) begin
            post = (n == 3);
            n++;
            @(posedge clk); #1;
        end
        post = 1'b0;
        check(n == WAIT, "R8 busy length", n, WAIT);
        rd(A_C, d); check(d == 32'h0D, "R8 pll selected R10 post ignored", d, 32'h0D);

        // R9 and R10: post-change handover with a stray pre request
        @(negedge clk); post = 1'b1;
        @(posedge clk); #1 post = 1'b0;
        rd(A_C, d); check(d == 32'h8D, "R9 restored", d, 32'h8D);
        n = 0;
        while (busy && n < 100) begin
            pre = (n == 2);
            n++;
            @(posedge clk); #1;
        end
        pre = 1'b0;
        check(n == WAIT, "R9 busy length", n, WAIT);
        @(posedge clk); #1;
        rd(A_C, d); check(d == 32'h8D, "R10 pre ignored", d, 32'h8D);
        check(busy == 1'b0, "R10 stays idle", busy, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule